// File: doc/BRIEF.md
# Synchronous Serial Character Receiver

This block takes serial characters from one data line that is accompanied by a separate bit clock. The line is looked at exactly once per rising edge of that bit clock; there is no oversampling and no search for the middle of a bit. While idle, the first low level seen at a sampling point is taken as a start bit. The receiver then collects a configurable number of data bits (least significant bit first), an optional parity bit and one or two stop bits, and goes back to waiting for the next start bit.

Everything runs on a single system clock. The bit clock is brought in through a synchronizer and turned into a one-cycle sample strobe; the data line passes through a synchronizer of the same depth so that both stay aligned. A finished character is moved into a holding register and a ready flag is raised. If the previous character was never read, the new one still replaces it and a sticky overrun flag is raised. Parity mismatches and low stop bits raise sticky error flags. A control write with the clear-status bit set clears all three sticky flags. A read strobe on the holding register clears only the ready flag.

Top module: `sync_char_rx`

## Requirements
- R1: The line is sampled only on the one system-clock strobe that follows each synchronized rising edge of `bit_clk_i`; with no such edge the receiver's frame state does not move.
- R2: While idle, a low sample is taken as a start bit; high samples while idle are ignored and leave the holding register and the flags unchanged.
- R3: Data bits arrive least significant bit first; the count comes from `cfg_len_i` (5 to 9, values below 5 act as 5, values above 9 act as 9), and holding-register bits above the character length read as 0.
- R4: When the last stop bit has been sampled, the character is written to `hold_data_o` and `rdy_o` is set.
- R5: A one-cycle pulse on `hold_rd_i` clears `rdy_o`; it does not change `ovr_o`, `par_err_o` or `frm_err_o`.
- R6: If a character completes while `rdy_o` is 1, `ovr_o` is set and the new character replaces the old one in `hold_data_o`.
- R7: `ovr_o`, `par_err_o` and `frm_err_o` are sticky; only a `ctrl_wr_i` pulse with `ctrl_clr_sta_i` = 1 clears them, and a control write with `ctrl_clr_sta_i` = 0 changes nothing.
- R8: `cfg_par_i` selects the parity bit: 0 none, 1 even (bit makes the count of ones even), 2 odd, 3 always 0, 4 always 1, 5 to 7 none; a received parity bit that differs from the expected one sets `par_err_o`.
- R9: `cfg_two_stop_i` = 1 selects two stop bits, 0 one; any stop bit sampled low sets `frm_err_o`, and the character is still delivered.
- R10: Length, parity mode and stop count are captured at the start bit; changing them during a character does not affect that character.
- R11: After reset `hold_data_o` is 0 and `rdy_o`, `ovr_o`, `par_err_o`, `frm_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bit_clk_i | input | 1 | Serial bit clock, asynchronous to clk_i |
| ser_i | input | 1 | Serial data line, idle high |
| cfg_len_i | input | 4 | Data bits per character (5 to 9) |
| cfg_par_i | input | 3 | Parity mode code |
| cfg_two_stop_i | input | 1 | 1 selects two stop bits |
| hold_rd_i | input | 1 | Holding-register read strobe |
| ctrl_wr_i | input | 1 | Control write strobe |
| ctrl_clr_sta_i | input | 1 | Clear-status bit of the control write |
| hold_data_o | output | 9 | Receive holding register |
| rdy_o | output | 1 | Character ready |
| ovr_o | output | 1 | Sticky overrun |
| par_err_o | output | 1 | Sticky parity error |
| frm_err_o | output | 1 | Sticky framing error |

## Verification
On every cycle the assertions check that the sample strobe is never two cycles long, that the frame state only moves on a strobe, that a low idle sample starts a frame, and that completion, read and clear act on the ready and sticky flags as required. Only the bench's scenarios can show that the bits end up in the right positions for each length, that every parity mode produces the right expected bit, that settings changed mid-character are ignored, and that idle-high traffic leaves the register untouched.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;

  localparam int unsigned MIN_CHAR_BITS = 5;

  localparam logic [2:0] PAR_NONE = 3'd0;
  localparam logic [2:0] PAR_EVEN = 3'd1;
  localparam logic [2:0] PAR_ODD  = 3'd2;
  localparam logic [2:0] PAR_ZERO = 3'd3;
  localparam logic [2:0] PAR_ONE  = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DATA  = 3'd1,
    ST_PAR   = 3'd2,
    ST_STOP1 = 3'd3,
    ST_STOP2 = 3'd4
  } rx_state_e;

  typedef struct packed {
    logic par_bad;
    logic frm_bad;
  } rx_flags_t;

  function automatic logic par_active(input logic [2:0] mode);
    return (mode == PAR_EVEN) || (mode == PAR_ODD) ||
           (mode == PAR_ZERO) || (mode == PAR_ONE);
  endfunction

endpackage

// File: rtl/bit_strobe_gen.sv
module bit_strobe_gen #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_clk_i,
  input  logic ser_i,
  output logic smp_en_o,
  output logic ser_s_o
);

  logic [SYNC_STAGES:0]   bclk_q, bclk_d;
  logic [SYNC_STAGES-1:0] ser_q, ser_d;

  always_comb begin
    bclk_d = {bclk_q[SYNC_STAGES-1:0], bit_clk_i};
    ser_d  = {ser_q[SYNC_STAGES-2:0], ser_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q <= '0;
      ser_q  <= '1;
    end else begin
      bclk_q <= bclk_d;
      ser_q  <= ser_d;
    end
  end

  assign smp_en_o = bclk_q[SYNC_STAGES-1] & ~bclk_q[SYNC_STAGES];
  assign ser_s_o  = ser_q[SYNC_STAGES-1];

  assert_strobe_single_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_en_o |=> !smp_en_o);

endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import sync_rx_pkg::*;
#(
  parameter int unsigned MAX_BITS = 9,
  parameter int unsigned CNT_W    = $clog2(MAX_BITS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                smp_en_i,
  input  logic                ser_i,
  input  logic [CNT_W-1:0]    cfg_len_i,
  input  logic [2:0]          cfg_par_i,
  input  logic                cfg_two_stop_i,
  output logic                done_o,
  output logic [MAX_BITS-1:0] data_o,
  output rx_flags_t           flags_o
);

  localparam logic [CNT_W-1:0] LEN_MIN = CNT_W'(MIN_CHAR_BITS);
  localparam logic [CNT_W-1:0] LEN_MAX = CNT_W'(MAX_BITS);

  rx_state_e             state_q, state_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic [CNT_W-1:0]      last_q, last_d;
  logic [2:0]            mode_q, mode_d;
  logic                  two_q, two_d;
  logic [MAX_BITS-1:0]   shr_q, shr_d;
  logic                  acc_q, acc_d;
  logic                  pbad_q, pbad_d;
  logic                  fbad_q, fbad_d;
  logic                  done_q, done_d;
  logic [CNT_W-1:0]      len_eff;
  logic                  par_exp;

  always_comb begin
    if (cfg_len_i < LEN_MIN)      len_eff = LEN_MIN;
    else if (cfg_len_i > LEN_MAX) len_eff = LEN_MAX;
    else                          len_eff = cfg_len_i;
  end

  always_comb begin
    case (mode_q)
      PAR_EVEN: par_exp = acc_q;
      PAR_ODD:  par_exp = ~acc_q;
      PAR_ONE:  par_exp = 1'b1;
      default:  par_exp = 1'b0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    last_d  = last_q;
    mode_d  = mode_q;
    two_d   = two_q;
    shr_d   = shr_q;
    acc_d   = acc_q;
    pbad_d  = pbad_q;
    fbad_d  = fbad_q;
    done_d  = 1'b0;
    if (smp_en_i) begin
      unique case (state_q)
        ST_IDLE: begin
          if (!ser_i) begin
            state_d = ST_DATA;
            cnt_d   = '0;
            last_d  = len_eff - 1'b1;
            mode_d  = cfg_par_i;
            two_d   = cfg_two_stop_i;
            shr_d   = '0;
            acc_d   = 1'b0;
            pbad_d  = 1'b0;
            fbad_d  = 1'b0;
          end
        end
        ST_DATA: begin
          for (int i = 0; i < MAX_BITS; i++) begin
            if (cnt_q == CNT_W'(i)) shr_d[i] = ser_i;
          end
          acc_d = acc_q ^ ser_i;
          if (cnt_q == last_q) begin
            state_d = par_active(mode_q) ? ST_PAR : ST_STOP1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_PAR: begin
          pbad_d  = (ser_i != par_exp);
          state_d = ST_STOP1;
        end
        ST_STOP1: begin
          fbad_d = ~ser_i;
          if (two_q) begin
            state_d = ST_STOP2;
          end else begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end
        end
        ST_STOP2: begin
          fbad_d  = fbad_q | ~ser_i;
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      last_q  <= '0;
      mode_q  <= PAR_NONE;
      two_q   <= 1'b0;
      shr_q   <= '0;
      acc_q   <= 1'b0;
      pbad_q  <= 1'b0;
      fbad_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      last_q  <= last_d;
      mode_q  <= mode_d;
      two_q   <= two_d;
      shr_q   <= shr_d;
      acc_q   <= acc_d;
      pbad_q  <= pbad_d;
      fbad_q  <= fbad_d;
      done_q  <= done_d;
    end
  end

  assign done_o          = done_q;
  assign data_o          = shr_q;
  assign flags_o.par_bad = pbad_q;
  assign flags_o.frm_bad = fbad_q;

  assert_state_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_en_i |=> $stable(state_q));

  assert_start_detect_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && smp_en_i && !ser_i) |=> (state_q == ST_DATA));

  assert_done_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (state_q == ST_IDLE));

  assert_len_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA) |-> (cnt_q <= last_q && last_q < LEN_MAX));

endmodule

// File: rtl/rx_hold_status.sv
module rx_hold_status
  import sync_rx_pkg::*;
#(
  parameter int unsigned MAX_BITS = 9
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                done_i,
  input  logic [MAX_BITS-1:0] data_i,
  input  rx_flags_t           flags_i,
  input  logic                hold_rd_i,
  input  logic                clr_sta_i,
  output logic [MAX_BITS-1:0] hold_o,
  output logic                rdy_o,
  output logic                ovr_o,
  output logic                perr_o,
  output logic                ferr_o
);

  logic [MAX_BITS-1:0] hold_q, hold_d;
  logic rdy_q, rdy_d, ovr_q, ovr_d, perr_q, perr_d, ferr_q, ferr_d;

  always_comb begin
    hold_d = hold_q;
    rdy_d  = rdy_q;
    ovr_d  = ovr_q;
    perr_d = perr_q;
    ferr_d = ferr_q;
    if (clr_sta_i) begin
      ovr_d  = 1'b0;
      perr_d = 1'b0;
      ferr_d = 1'b0;
    end
    if (hold_rd_i) rdy_d = 1'b0;
    if (done_i) begin
      hold_d = data_i;
      rdy_d  = 1'b1;
      if (rdy_q && !hold_rd_i) ovr_d = 1'b1;
      if (flags_i.par_bad)     perr_d = 1'b1;
      if (flags_i.frm_bad)     ferr_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      rdy_q  <= 1'b0;
      ovr_q  <= 1'b0;
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      hold_q <= hold_d;
      rdy_q  <= rdy_d;
      ovr_q  <= ovr_d;
      perr_q <= perr_d;
      ferr_q <= ferr_d;
    end
  end

  assign hold_o = hold_q;
  assign rdy_o  = rdy_q;
  assign ovr_o  = ovr_q;
  assign perr_o = perr_q;
  assign ferr_o = ferr_q;

  assert_done_loads_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (rdy_o && hold_o == $past(data_i)));

  assert_read_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_rd_i && !done_i) |=> !rdy_o);

  assert_overrun_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && rdy_o && !hold_rd_i) |=> ovr_o);

  assert_sticky_ovr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !clr_sta_i) |=> ovr_o);

  assert_sticky_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_sta_i && (perr_o || ferr_o)) |=> (perr_o >= $past(perr_o) && ferr_o >= $past(ferr_o)));

  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_sta_i && !done_i) |=> (!ovr_o && !perr_o && !ferr_o));

endmodule

// File: rtl/sync_char_rx.sv
module sync_char_rx
  import sync_rx_pkg::*;
#(
  parameter int unsigned MAX_BITS    = 9,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_W      = $clog2(MAX_BITS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bit_clk_i,
  input  logic                ser_i,
  input  logic [CNT_W-1:0]    cfg_len_i,
  input  logic [2:0]          cfg_par_i,
  input  logic                cfg_two_stop_i,
  input  logic                hold_rd_i,
  input  logic                ctrl_wr_i,
  input  logic                ctrl_clr_sta_i,
  output logic [MAX_BITS-1:0] hold_data_o,
  output logic                rdy_o,
  output logic                ovr_o,
  output logic                par_err_o,
  output logic                frm_err_o
);

  logic                smp_en;
  logic                ser_s;
  logic                done;
  logic [MAX_BITS-1:0] char_data;
  rx_flags_t           char_flags;
  logic                clr_sta;

  assign clr_sta = ctrl_wr_i & ctrl_clr_sta_i;

  bit_strobe_gen #(.SYNC_STAGES(SYNC_STAGES)) u_strobe (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_clk_i (bit_clk_i),
    .ser_i     (ser_i),
    .smp_en_o  (smp_en),
    .ser_s_o   (ser_s)
  );

  rx_frame_fsm #(.MAX_BITS(MAX_BITS), .CNT_W(CNT_W)) u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .smp_en_i       (smp_en),
    .ser_i          (ser_s),
    .cfg_len_i      (cfg_len_i),
    .cfg_par_i      (cfg_par_i),
    .cfg_two_stop_i (cfg_two_stop_i),
    .done_o         (done),
    .data_o         (char_data),
    .flags_o        (char_flags)
  );

  rx_hold_status #(.MAX_BITS(MAX_BITS)) u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .done_i    (done),
    .data_i    (char_data),
    .flags_i   (char_flags),
    .hold_rd_i (hold_rd_i),
    .clr_sta_i (clr_sta),
    .hold_o    (hold_data_o),
    .rdy_o     (rdy_o),
    .ovr_o     (ovr_o),
    .perr_o    (par_err_o),
    .ferr_o    (frm_err_o)
  );

  assert_ctrl_noclr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr_i && !ctrl_clr_sta_i && ovr_o) |=> ovr_o);

endmodule

// File: tb/sync_char_rx_tb_top.sv
module sync_char_rx_tb_top;

  logic       clk, rst_n;
  logic       bclk, ser;
  logic [3:0] cfg_len;
  logic [2:0] cfg_par;
  logic       cfg_two;
  logic       hrd, cwr, cclr;
  logic [8:0] hold;
  logic       rdy, ovr, perr, ferr;

  int n_chk, n_bad;
  logic [8:0] e_hold;
  logic e_rdy, e_ovr, e_perr, e_ferr;

  sync_char_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bit_clk_i(bclk), .ser_i(ser),
    .cfg_len_i(cfg_len), .cfg_par_i(cfg_par), .cfg_two_stop_i(cfg_two),
    .hold_rd_i(hrd), .ctrl_wr_i(cwr), .ctrl_clr_sta_i(cclr),
    .hold_data_o(hold), .rdy_o(rdy), .ovr_o(ovr),
    .par_err_o(perr), .frm_err_o(ferr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int eff_len(input int n);
    if (n < 5) return 5;
    if (n > 9) return 9;
    return n;
  endfunction

  function automatic bit par_on(input int m);
    return (m >= 1 && m <= 4);
  endfunction

  function automatic logic par_bit(input logic [8:0] d, input int n, input int m);
    logic x;
    x = 1'b0;
    for (int i = 0; i < n; i++) x = x ^ d[i];
    case (m)
      1: return x;
      2: return ~x;
      4: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check({req, " hold"}, hold, e_hold);
    check({req, " rdy"},  {8'd0, rdy},  {8'd0, e_rdy});
    check({req, " ovr"},  {8'd0, ovr},  {8'd0, e_ovr});
    check({req, " perr"}, {8'd0, perr}, {8'd0, e_perr});
    check({req, " ferr"}, {8'd0, ferr}, {8'd0, e_ferr});
  endtask

  task automatic bit_out(input logic b);
    @(negedge clk);
    ser  = b;
    bclk = 1'b0;
    repeat (4) @(negedge clk);
    bclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // Sends one character; settings are scrambled after the start bit (R10).
  task automatic send_char(input logic [8:0] d, input int n, input int m,
                           input bit two, input bit badp, input bit bads);
    int nl;
    logic [8:0] msk;
    nl = eff_len(n);
    cfg_len = 4'(n);
    cfg_par = 3'(m);
    cfg_two = two;
    bit_out(1'b0);
    cfg_len = 4'($urandom_range(0, 15));
    cfg_par = 3'($urandom_range(0, 7));
    cfg_two = 1'($urandom_range(0, 1));
    for (int i = 0; i < nl; i++) bit_out(d[i]);
    if (par_on(m)) bit_out(par_bit(d, nl, m) ^ badp);
    if (two) begin
      bit_out(1'b1);
      bit_out(~bads);
    end else begin
      bit_out(~bads);
    end
    bit_out(1'b1);
    bit_out(1'b1);
    msk = 9'((1 << nl) - 1);
    if (e_rdy) e_ovr = 1'b1;
    e_rdy  = 1'b1;
    e_hold = d & msk;
    if (par_on(m) && badp) e_perr = 1'b1;
    if (bads) e_ferr = 1'b1;
  endtask

  task automatic rd_hold();
    @(negedge clk); hrd = 1'b1;
    @(negedge clk); hrd = 1'b0;
    @(negedge clk);
    e_rdy = 1'b0;
  endtask

  task automatic ctrl(input bit clr);
    @(negedge clk); cwr = 1'b1; cclr = clr;
    @(negedge clk); cwr = 1'b0; cclr = 1'b0;
    @(negedge clk);
    if (clr) begin e_ovr = 0; e_perr = 0; e_ferr = 0; end
  endtask

  initial begin
    #1500000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    n_chk = 0; n_bad = 0;
    rst_n = 0; bclk = 0; ser = 1; cfg_len = 8; cfg_par = 1; cfg_two = 0;
    hrd = 0; cwr = 0; cclr = 0;
    e_hold = 0; e_rdy = 0; e_ovr = 0; e_perr = 0; e_ferr = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R11 reset");

    // R2: idle high samples ignored
    repeat (6) bit_out(1'b1);
    check_all("R2 idle");

    // R4 R3 R8: 8 bits, even parity, one stop
    send_char(9'h0A5, 8, 1, 0, 0, 0);
    check_all("R4 R3 R8 basic");
    rd_hold();
    check_all("R5 read");

    // R6: overrun, new char replaces old
    send_char(9'h013, 5, 0, 0, 0, 0);
    send_char(9'h1FF, 9, 2, 1, 0, 0);
    check_all("R6 overrun");
    rd_hold();
    check_all("R5 read keeps ovr");
    ctrl(0);
    check_all("R7 write no clear");
    ctrl(1);
    check_all("R7 clear");

    // R8 parity error, R9 framing error with two stops
    send_char(9'h03C, 7, 3, 0, 1, 0);
    check_all("R8 forced zero bad");
    rd_hold();
    send_char(9'h155, 9, 4, 1, 0, 1);
    check_all("R9 two stop bad");
    rd_hold();
    ctrl(1);
    check_all("R7 clear errors");

    // R3: length clamp
    send_char(9'h1FF, 2, 0, 0, 0, 0);
    check_all("R3 clamp low");
    rd_hold();
    send_char(9'h1FF, 14, 0, 0, 0, 0);
    check_all("R3 clamp high");
    rd_hold();

    // Random traffic, R10 settings scrambled mid-character
    for (int k = 0; k < 40; k++) begin
      send_char(9'($urandom_range(0, 511)), $urandom_range(3, 11),
                $urandom_range(0, 7), 1'($urandom_range(0, 1)),
                ($urandom_range(0, 5) == 0), ($urandom_range(0, 5) == 0));
      check_all("R10 R8 R9 random");
      if ($urandom_range(0, 1) == 1) rd_hold();
      if ($urandom_range(0, 3) == 0) ctrl(1'($urandom_range(0, 1)));
      check_all("R5 R7 random");
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule